// File: doc/BRIEF.md
# Frame-buffer UART streamer

This block sends one complete sensor frame to a host over a transmit-only asynchronous serial line. A single-cycle trigger starts it. It then walks a frame memory from the lowest address upward and sends every byte as an 8N1 character. When the last character's stop bit has ended, it goes back to idle. One trigger moves the whole buffer, with no per-byte request from outside.

The memory is read through an address output and a data input, with one cycle of read latency. A frame is `FRAME_BYTES` bytes, 256 by default. The bit time is a whole number of system clock cycles, derived from the clock frequency and the line rate (115200 baud by default). While a frame is in flight the block holds a busy flag high. A further trigger during that time does nothing.

Top module: `frame_uart_streamer`

## Requirements
- R1: Out of reset, `txLine` is high and `busy` is low. `txLine` stays high at every cycle in which `busy` is low.
- R2: A `frameReady` pulse sampled while idle sets `busy` at that same clock edge. The start bit of the first character begins exactly 2 clock cycles after that edge.
- R3: Each character is one low start bit, then 8 data bits with bit 0 first, then one high stop bit. Every bit lasts BIT_CYCLES = round(CLK_HZ / BAUD) clock cycles.
- R4: Characters carry the memory contents at addresses 0, 1, ..., FRAME_BYTES-1, in that order. `memAddr` only ever steps up by one while a frame is in flight. `memData` is taken as valid one cycle after `memAddr` presents an address.
- R5: Consecutive start bits are exactly 10 bit times apart, so there is no idle time between characters beyond the stop bit.
- R6: `busy` falls at the clock edge that ends the last stop bit, exactly 2 + FRAME_BYTES*10*BIT_CYCLES cycles after the trigger edge. The line then stays high.
- R7: A `frameReady` pulse while `busy` is high is ignored. The frame's content and end time are unchanged, and no further frame follows it.
- R8: A trigger given right after a frame has finished starts a fresh frame from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameReady | input | 1 | One-cycle pulse that starts sending a frame |
| memAddr | output | $clog2(FRAME_BYTES) | Read address to the frame memory |
| memData | input | DATA_W | Read data, valid one cycle after the address |
| busy | output | 1 | High while a frame is being sent |
| txLine | output | 1 | Serial transmit line, idles high |

## Verification
The bench counts clock edges from the trigger edge. It expects `busy` at the first falling edge after the trigger and the first start bit 2 cycles later. After that, each start bit is due 10 bit times after the previous one, and `busy` must drop 2 + FRAME_BYTES*10*BIT_CYCLES cycles after the trigger. Each start fall is located on a falling clock edge. The start, data and stop bits are then sampled at the middle of each bit time, and the recorded edge counts are compared with those due values exactly. A short bit time is set through the parameters so that several full 256-byte frames fit in the run.

// File: rtl/streamer_pkg.sv
package streamer_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic addrClear;   // restart the read address at zero
    logic loadByte;    // capture memory data into the shifter, advance address
    logic shiftBit;    // move the shifter on by one bit time
  } ctrlStrobes_t;
endpackage

// File: rtl/streamer_datapath.sv
module streamer_datapath
  import streamer_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int FRAME_BYTES = 256,
  parameter int ADDR_W      = $clog2(FRAME_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              sendingLast,
  output logic              txLine
);
  localparam int SHIFT_W = DATA_W + 2;
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_BYTES - 1);

  logic [SHIFT_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '1;
      memAddr     <= '0;
      sendingLast <= 1'b0;
    end else begin
      if (strobes.addrClear) begin
        memAddr     <= '0;
        sendingLast <= 1'b0;
      end
      if (strobes.loadByte) begin
        shiftReg <= {1'b1, memData, 1'b0};
        if (memAddr == LAST_ADDR) sendingLast <= 1'b1;
        else                      memAddr     <= memAddr + 1'b1;
      end else if (strobes.shiftBit) begin
        shiftReg <= {1'b1, shiftReg[SHIFT_W-1:1]};
      end
    end
  end

  assign txLine = shiftReg[0];
endmodule

// File: rtl/streamer_ctrl.sv
module streamer_ctrl
  import streamer_pkg::*;
#(
  parameter int BIT_CYCLES = 1085,
  parameter int CHAR_BITS  = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameReady,
  input  logic         sendingLast,
  output logic         busy,
  output ctrlStrobes_t strobes
);
  localparam int BAUD_W = $clog2(BIT_CYCLES + 1);
  localparam int BITC_W = $clog2(CHAR_BITS + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PRIME, ST_SEND} state_t;

  state_t              state;
  logic                primeDone;
  logic [BAUD_W-1:0]   baudCnt;
  logic [BITC_W-1:0]   bitCnt;
  logic                bitEnd;
  logic                charEnd;

  assign bitEnd  = (state == ST_SEND) && (baudCnt == BAUD_W'(BIT_CYCLES - 1));
  assign charEnd = bitEnd && (bitCnt == BITC_W'(CHAR_BITS - 1));

  always_comb begin
    strobes = '0;
    strobes.addrClear = (state == ST_IDLE) && frameReady;
    strobes.loadByte  = ((state == ST_PRIME) && primeDone) || (charEnd && !sendingLast);
    strobes.shiftBit  = bitEnd && !(charEnd && !sendingLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      primeDone <= 1'b0;
      baudCnt   <= '0;
      bitCnt    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (frameReady) begin
            state     <= ST_PRIME;
            primeDone <= 1'b0;
          end
        end
        ST_PRIME: begin
          primeDone <= 1'b1;
          if (primeDone) begin
            state   <= ST_SEND;
            baudCnt <= '0;
            bitCnt  <= '0;
          end
        end
        ST_SEND: begin
          if (bitEnd) begin
            baudCnt <= '0;
            if (charEnd) begin
              bitCnt <= '0;
              if (sendingLast) state <= ST_IDLE;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end else begin
            baudCnt <= baudCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/frame_uart_streamer.sv
module frame_uart_streamer
  import streamer_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int BAUD        = 115_200,
  parameter int FRAME_BYTES = 256,
  parameter int DATA_W      = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           frameReady,
  output logic [$clog2(FRAME_BYTES)-1:0] memAddr,
  input  logic [DATA_W-1:0]              memData,
  output logic                           busy,
  output logic                           txLine
);
  localparam int BIT_CYCLES = (CLK_HZ + BAUD / 2) / BAUD;
  localparam int ADDR_W     = $clog2(FRAME_BYTES);
  localparam int CHAR_BITS  = DATA_W + 2;

  ctrlStrobes_t strobes;
  logic         sendingLast;

  streamer_ctrl #(
    .BIT_CYCLES(BIT_CYCLES),
    .CHAR_BITS (CHAR_BITS)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameReady (frameReady),
    .sendingLast(sendingLast),
    .busy       (busy),
    .strobes    (strobes)
  );

  streamer_datapath #(
    .DATA_W     (DATA_W),
    .FRAME_BYTES(FRAME_BYTES),
    .ADDR_W     (ADDR_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .memData    (memData),
    .memAddr    (memAddr),
    .sendingLast(sendingLast),
    .txLine     (txLine)
  );
endmodule

// File: rtl/streamer_checker.sv
module streamer_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic              busy,
  input logic              txLine
);
  // R1: line rests high whenever no frame is in flight
  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> txLine);

  // R2: an idle trigger raises busy at the sampling edge
  assert_trigger_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && frameReady) |=> busy);

  // R4: address only steps up by one during a frame
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (memAddr != $past(memAddr))) |-> (memAddr == $past(memAddr) + 1'b1));

  // R6: frame ends on a completed high stop bit
  assert_end_stop_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (txLine && $past(txLine)));

  // R7: a trigger during a frame never restarts the address walk
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && frameReady && (memAddr != '0)) |=> (memAddr != '0));
endmodule

bind frame_uart_streamer streamer_checker #(.ADDR_W($clog2(FRAME_BYTES))) i_checker (
  .clk       (clk),
  .rstN      (rstN),
  .frameReady(frameReady),
  .memAddr   (memAddr),
  .busy      (busy),
  .txLine    (txLine)
);

// File: tb/test_frame_uart_streamer.sv
module test_frame_uart_streamer;
  localparam int CLK_HZ  = 1_152_000;
  localparam int BAUD    = 115_200;
  localparam int FB      = 256;
  localparam int BIT_T   = 10;          // CLK_HZ / BAUD
  localparam int CHAR_T  = 10 * BIT_T;
  localparam int FRAME_T = 2 + FB * CHAR_T;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameReady = 1'b0;
  logic [7:0] memAddr;
  logic [7:0] memData = 8'h00;
  logic       busy;
  logic       txLine;

  logic [7:0] frameMem [FB];
  int         cycleCnt = 0;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;   // 125 MHz
  always @(posedge clk) cycleCnt <= cycleCnt + 1;
  always @(posedge clk) memData <= frameMem[memAddr];

  frame_uart_streamer #(
    .CLK_HZ(CLK_HZ), .BAUD(BAUD), .FRAME_BYTES(FB), .DATA_W(8)
  ) i_frame_uart_streamer (
    .clk(clk), .rstN(rstN), .frameReady(frameReady), .memAddr(memAddr),
    .memData(memData), .busy(busy), .txLine(txLine)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fillMem(input int kind);
    for (int i = 0; i < FB; i++) begin
      case (kind)
        0:       frameMem[i] = 8'(i) ^ 8'hA5;
        1:       frameMem[i] = (i % 2 == 0) ? 8'h00 : 8'hFF;
        default: frameMem[i] = 8'(i * 37 + 11);
      endcase
    end
  endtask

  // pulse frameReady for one cycle; returns the cycle count of the sampling edge
  task automatic trigger(output int c0);
    @(negedge clk);
    check(txLine === 1'b1 && busy === 1'b0, "R1", "idle before trigger", int'(txLine), 1);
    frameReady = 1'b1;
    @(negedge clk);
    frameReady = 1'b0;
    c0 = cycleCnt;
    check(busy === 1'b1, "R2", "busy after trigger", int'(busy), 1);
  endtask

  task automatic recvFrame(input int c0, input string tag);
    int prevStart = 0;
    for (int i = 0; i < FB; i++) begin
      int startCyc;
      logic [7:0] rx;
      bit okBits = 1;
      do @(negedge clk); while (txLine !== 1'b0);
      startCyc = cycleCnt;
      if (i == 0) check(startCyc - c0 == 2, "R2", {tag, " first start latency"}, startCyc - c0, 2);
      else if (startCyc - prevStart != CHAR_T)
        check(0, "R5", {tag, " start spacing"}, startCyc - prevStart, CHAR_T);
      prevStart = startCyc;
      repeat (BIT_T / 2) @(negedge clk);
      if (txLine !== 1'b0) okBits = 0;
      for (int b = 0; b < 8; b++) begin
        repeat (BIT_T) @(negedge clk);
        rx[b] = txLine;
      end
      repeat (BIT_T) @(negedge clk);
      if (txLine !== 1'b1) okBits = 0;
      if (!okBits) check(0, "R3", {tag, " start/stop level"}, i, -1);
      check(rx === frameMem[i], "R4", {tag, " byte value"}, int'(rx), int'(frameMem[i]));
    end
    check(1, "R5", {tag, " spacing"}, 0, 0);
    while (busy === 1'b1) @(negedge clk);
    check(cycleCnt - c0 == FRAME_T, "R6", {tag, " busy fall cycle"}, cycleCnt - c0, FRAME_T);
  endtask

  task automatic checkQuiet(input int cycles, input string req);
    bit ok = 1;
    repeat (cycles) begin
      @(negedge clk);
      if (txLine !== 1'b1 || busy !== 1'b0) ok = 0;
    end
    check(ok, req, "line idle after frame", int'(ok), 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(txLine === 1'b1, "R1", "tx at reset", int'(txLine), 1);
    check(busy === 1'b0, "R1", "busy at reset", int'(busy), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txLine === 1'b1 && busy === 1'b0, "R1", "idle after reset", int'(txLine), 1);
  endtask

  task automatic testFrame(input int kind, input string tag);
    int c0;
    fillMem(kind);
    trigger(c0);
    recvFrame(c0, tag);
    checkQuiet(2 * CHAR_T, "R6");
  endtask

  task automatic testIgnoredTrigger();
    int c0;
    fillMem(2);
    trigger(c0);
    fork
      recvFrame(c0, "R7 frame");
      begin
        repeat (3000) @(negedge clk);
        frameReady = 1'b1;
        @(negedge clk);
        frameReady = 1'b0;
        check(busy === 1'b1, "R7", "busy kept through extra trigger", int'(busy), 1);
      end
    join
    checkQuiet(3 * CHAR_T, "R7");
  endtask

  task automatic testBackToBack();
    int c0;
    fillMem(0);
    trigger(c0);
    recvFrame(c0, "R8 first");
    fillMem(1);
    trigger(c0);
    recvFrame(c0, "R8 second");
  endtask

  initial begin
    repeat (200_000) @(posedge clk);
    check(0, "WATCHDOG", "run did not finish", cycleCnt, 200_000);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    testReset();
    testFrame(0, "R3 pattern xor");
    testFrame(1, "R4 pattern alternate");
    testIgnoredTrigger();
    testBackToBack();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule